// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into an asynchronous serial bit stream. Each frame has one low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period. The block is clocked by the system clock. It advances only on cycles where a baud enable, running at sixteen times the bit rate, is high. A break control holds the line low. The byte path can be set to one of two modes. In single-holding mode one byte waits in front of the shift stage. In queued mode a 16-entry first-in first-out store feeds the shift stage.

The host writes through a valid/ready port, and a byte is taken on a clock edge where both `wr_valid` and `wr_ready` are high. The host should hold `wr_valid` and `wr_data` steady until it sees `wr_ready` high. A byte offered while `wr_ready` is low is not taken and is lost; it leaves the stored bytes unchanged. Two status pins report whether bytes are waiting and whether the whole transmitter has gone quiet. The frame settings are plain level inputs. The block captures them at the start of each frame.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress and `brk` is low, `txd` is high. After reset `wr_ready`, `thr_empty` and `tx_empty` are all high.
- R2: A frame starts with a low start bit lasting 16 baud enables. Data bits follow, least significant first, 16 baud enables each. `char_len` selects the count of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: When `par_en` is 1, one parity bit lasting 16 baud enables follows the data bits. With `par_even` = 1 it makes the number of ones in data plus parity even; with `par_even` = 0 it makes that number odd.
- R4: With `stop_long` = 0 the stop period is 16 baud enables high. With `stop_long` = 1 it is 32, except for 5-bit characters, where it is 24.
- R5: `char_len`, `par_en`, `par_even` and `stop_long` are sampled on the clock edge where a frame begins. Changing them during a frame does not alter that frame.
- R6: The cycle after `brk` is seen high, `txd` is low, and it stays low for as long as `brk` stays high. Frame timing continues underneath.
- R7: In single-holding mode (`fifo_mode` = 0) at most one byte waits. `wr_ready` is low while it is held, and a byte offered then is discarded.
- R8: In queued mode (`fifo_mode` = 1) up to 16 bytes wait. `wr_ready` is low when 16 are stored, a byte offered then is discarded, and the stored bytes are sent intact and in the order they were written.
- R9: `thr_empty` is high exactly when no byte is waiting. `tx_empty` is high exactly when no byte is waiting and no frame, including its stop period, is being sent.
- R10: When a byte is waiting as a stop period ends, its start bit begins on the next clock with no idle gap. From an idle line, a waiting byte starts one clock after it was written.
- R11: A change of `fifo_mode` discards every waiting byte but not the frame on the line. `wr_ready` is low in the cycle where `fifo_mode` differs from the mode in use.
- R12: Bit timing advances only on cycles with `baud_tick` high, whatever the spacing between those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| fifo_mode | input | 1 | 1 selects the 16-entry queue, 0 selects the single holding byte |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Insert a parity bit |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| stop_long | input | 1 | Long stop period (2 bits, or 1.5 bits for 5-bit characters) |
| brk | input | 1 | Force the line low |
| wr_valid | input | 1 | Host offers a byte |
| wr_ready | output | 1 | Block can take a byte this cycle |
| wr_data | input | 8 | Byte offered by the host |
| txd | output | 1 | Serial line, registered, idle high |
| thr_empty | output | 1 | No byte waiting |
| tx_empty | output | 1 | No byte waiting and no frame in progress |

## Verification
Several properties are checked on every cycle:
- the stored count never exceeds the capacity of the active mode;
- the count changes by at most one entry per clock;
- a mode change leaves the store empty;
- the bit timer holds still on cycles without a baud enable;
- the line goes low two cycles after a frame is loaded;
- the line stays high after a quiet cycle and low after a break cycle.

Other behaviour shows only in the bench's scenarios, where a queue-based reference model predicts every line level, flag and ready value:
- the exact framing for each character length, parity and stop setting;
- that settings are captured at frame start;
- that a discarded write leaves the byte order intact;
- that frames follow each other back to back.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len;       // data bits minus five
    logic       par_en;
    logic       par_even;
    logic       stop_long;
  } frame_cfg_t;

  // Index of the last data bit of a frame (4..7).
  function automatic logic [2:0] last_bit_idx(input logic [1:0] len);
    return 3'd4 + {1'b0, len};
  endfunction

  // Stop period measured in half-bit units.
  function automatic logic [2:0] stop_halves(input frame_cfg_t cfg);
    if (!cfg.stop_long)       return 3'd2;
    else if (cfg.len == 2'd0) return 3'd3;
    else                      return 3'd4;
  endfunction

  // Parity over the active data bits only.
  function automatic logic parity_of(input logic [BYTE_W-1:0] d,
                                     input frame_cfg_t cfg);
    logic [BYTE_W-1:0] mask;
    logic ones_odd;
    mask     = 8'hFF >> (2'd3 - cfg.len);
    ones_odd = ^(d & mask);
    return cfg.par_even ? ones_odd : ~ones_odd;
  endfunction

endpackage

// File: rtl/sertx_buf.sv
`timescale 1ns/1ps
module sertx_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ready_o,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          has_data_o,
  output logic          empty_o
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = AW + 1;
  localparam logic [CNTW-1:0] CAP_Q   = CNTW'(DEPTH);
  localparam logic [CNTW-1:0] CAP_ONE = CNTW'(1);
  localparam logic [AW-1:0]   LAST_IX = AW'(DEPTH - 1);

  logic [DW-1:0]   mem_q [DEPTH];
  logic [AW-1:0]   rd_q, wr_q;
  logic [CNTW-1:0] count_q;
  logic            mode_q;
  logic            flush;
  logic [CNTW-1:0] cap;
  logic            push;

  assign flush      = (fifo_mode_i != mode_q);
  assign cap        = mode_q ? CAP_Q : CAP_ONE;
  assign wr_ready_o = !flush && (count_q < cap);
  assign push       = wr_valid_i && wr_ready_o;
  assign has_data_o = !flush && (count_q != '0);
  assign empty_o    = (count_q == '0);
  assign head_o     = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_IX) ? '0 : p + AW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && (wr_q == AW'(i))) mem_q[i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      count_q <= '0;
      mode_q  <= 1'b0;
    end else begin
      mode_q <= fifo_mode_i;
      if (flush) begin
        rd_q    <= '0;
        wr_q    <= '0;
        count_q <= '0;
      end else begin
        if (push)  wr_q <= nxt(wr_q);
        if (pop_i) rd_q <= nxt(rd_q);
        case ({push, pop_i})
          2'b10:   count_q <= count_q + CNTW'(1);
          2'b01:   count_q <= count_q - CNTW'(1);
          default: count_q <= count_q;
        endcase
      end
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CAP_Q);

  p_char_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !$past(mode_q)) |-> (count_q <= CAP_ONE));

  p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (count_q == '0));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flush) |-> ((int'(count_q) <= int'($past(count_q)) + 1) &&
                       (int'(count_q) + 1 >= int'($past(count_q)))));

endmodule

// File: rtl/sertx_bittimer.sv
`timescale 1ns/1ps
module sertx_bittimer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  logic half_i,
  output logic bit_end_o
);
  localparam int CW = $clog2(TICKS);
  localparam logic [CW-1:0] FULL_LIM = CW'(TICKS - 1);
  localparam logic [CW-1:0] HALF_LIM = CW'(TICKS / 2 - 1);

  logic [CW-1:0] tcnt_q;
  logic [CW-1:0] lim;

  assign lim       = half_i ? HALF_LIM : FULL_LIM;
  assign bit_end_o = run_i && tick_i && (tcnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)          tcnt_q <= '0;
    else if (!run_i)     tcnt_q <= '0;
    else if (tick_i)     tcnt_q <= bit_end_o ? '0 : tcnt_q + CW'(1);
  end

  p_tick_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(tcnt_q));

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_i) |-> (tcnt_q == '0));

endmodule

// File: rtl/sertx_framer.sv
`timescale 1ns/1ps
module sertx_framer
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  frame_cfg_t        cfg_i,
  input  logic              has_data_i,
  input  logic [BYTE_W-1:0] head_i,
  input  logic              bit_end_i,
  output logic              pop_o,
  output logic              busy_o,
  output logic              half_o,
  output logic              line_o
);
  tx_state_e         state_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [2:0]        bitcnt_q;
  logic [2:0]        halves_q;
  frame_cfg_t        cfg_q;
  logic              par_q;
  logic              frame_end;

  assign frame_end = (state_q == ST_STOP) && bit_end_i && (halves_q == 3'd1);
  assign pop_o     = has_data_i && ((state_q == ST_IDLE) || frame_end);
  assign busy_o    = (state_q != ST_IDLE);
  assign half_o    = (state_q == ST_STOP);

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg_q[0];
      ST_PAR:   line_o = par_q;
      default:  line_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      halves_q <= '0;
      cfg_q    <= '0;
      par_q    <= 1'b0;
    end else if (pop_o) begin
      state_q  <= ST_START;
      shreg_q  <= head_i;
      bitcnt_q <= '0;
      cfg_q    <= cfg_i;
      par_q    <= parity_of(head_i, cfg_i);
    end else begin
      case (state_q)
        ST_START: if (bit_end_i) state_q <= ST_DATA;
        ST_DATA: if (bit_end_i) begin
          if (bitcnt_q == last_bit_idx(cfg_q.len)) begin
            state_q  <= cfg_q.par_en ? ST_PAR : ST_STOP;
            halves_q <= stop_halves(cfg_q);
          end else begin
            shreg_q  <= shreg_q >> 1;
            bitcnt_q <= bitcnt_q + 3'd1;
          end
        end
        ST_PAR: if (bit_end_i) begin
          state_q  <= ST_STOP;
          halves_q <= stop_halves(cfg_q);
        end
        ST_STOP: if (bit_end_i) begin
          if (halves_q == 3'd1) state_q <= ST_IDLE;
          else                  halves_q <= halves_q - 3'd1;
        end
        default: ;
      endcase
    end
  end

  p_halves_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> ((halves_q >= 3'd1) && (halves_q <= 3'd4)));

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(pop_o)) |-> $stable(cfg_q));

endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       fifo_mode,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       stop_long,
  input  logic       brk,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       thr_empty,
  output logic       tx_empty
);
  frame_cfg_t        cfg;
  logic              pop, has_data, busy, half, line, bit_end;
  logic [BYTE_W-1:0] head;
  logic              txd_q;

  assign cfg = '{len: char_len, par_en: par_en, par_even: par_even,
                 stop_long: stop_long};

  sertx_buf #(.DEPTH(DEPTH), .DW(BYTE_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo_mode),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .pop_i(pop), .head_o(head), .has_data_o(has_data), .empty_o(thr_empty)
  );

  sertx_bittimer #(.TICKS(TICKS_PER_BIT)) tmr_i (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .tick_i(baud_tick),
    .half_i(half), .bit_end_o(bit_end)
  );

  sertx_framer frm_i (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .has_data_i(has_data),
    .head_i(head), .bit_end_i(bit_end), .pop_o(pop), .busy_o(busy),
    .half_o(half), .line_o(line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) txd_q <= 1'b1;
    else        txd_q <= ~brk & line;
  end

  assign txd      = txd_q;
  assign tx_empty = thr_empty && !busy;

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pop, 2) && !$past(brk)) |-> !txd);

  p_brk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(brk) |-> !txd);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_empty) && !$past(brk)) |-> txd);

endmodule

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       fifo_mode = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0, par_even = 1'b0, stop_long = 1'b0, brk = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, txd, thr_empty, tx_empty;

  int tests = 0, fails = 0;
  int tick_div = 1, tick_cnt = 0;
  bit done = 0;

  sertx_top dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .fifo_mode(fifo_mode),
    .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .stop_long(stop_long), .brk(brk), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin baud_tick <= 1'b1; tick_cnt <= 0; end
    else begin baud_tick <= 1'b0; tick_cnt <= tick_cnt + 1; end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int    q[$];
  bit    m_busy = 0;
  bit    m_mode = 0;
  int    seg_lvl[$], seg_len[$];
  string seg_tag[$];
  int    exp_txd = 1;
  string exp_tag = "R1";

  function automatic void load_frame(int b);
    int n, ones, p;
    n = 5 + int'(char_len);
    ones = 0;
    seg_lvl.push_back(0); seg_len.push_back(16); seg_tag.push_back("R2");
    for (int i = 0; i < n; i++) begin
      seg_lvl.push_back((b >> i) & 1); seg_len.push_back(16); seg_tag.push_back("R2");
      ones += (b >> i) & 1;
    end
    if (par_en) begin
      p = par_even ? (ones & 1) : ((ones + 1) & 1);
      seg_lvl.push_back(p); seg_len.push_back(16); seg_tag.push_back("R3");
    end
    seg_lvl.push_back(1);
    seg_len.push_back(!stop_long ? 16 : (char_len == 2'd0 ? 24 : 32));
    seg_tag.push_back("R4");
    m_busy = 1;
  endfunction

  function automatic void model_step();
    bit flush, rdy;
    int cap;
    if (brk) begin exp_txd = 0; exp_tag = "R6"; end
    else if (m_busy) begin exp_txd = seg_lvl[0]; exp_tag = seg_tag[0]; end
    else begin exp_txd = 1; exp_tag = "R1"; end
    flush = (fifo_mode != m_mode);
    cap   = m_mode ? 16 : 1;
    rdy   = !flush && (q.size() < cap);
    if (m_busy && baud_tick) begin
      seg_len[0] = seg_len[0] - 1;
      if (seg_len[0] == 0) begin
        void'(seg_lvl.pop_front()); void'(seg_len.pop_front()); void'(seg_tag.pop_front());
        if (seg_lvl.size() == 0) m_busy = 0;
      end
    end
    if (!m_busy && !flush && q.size() > 0) load_frame(q.pop_front());
    if (wr_valid && rdy) q.push_back(int'(wr_data));
    if (flush) q.delete();
    m_mode = fifo_mode;
  endfunction

  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      #5;
      chk(int'(txd) == exp_txd, exp_tag, "txd", int'(txd), exp_txd);
      chk(wr_ready == ((fifo_mode == m_mode) && (q.size() < (m_mode ? 16 : 1))),
          (fifo_mode != m_mode) ? "R11" : (m_mode ? "R8" : "R7"), "wr_ready",
          int'(wr_ready), int'((fifo_mode == m_mode) && (q.size() < (m_mode ? 16 : 1))));
      chk(thr_empty == (q.size() == 0), "R9", "thr_empty", int'(thr_empty),
          int'(q.size() == 0));
      chk(tx_empty == (q.size() == 0 && !m_busy), "R9", "tx_empty", int'(tx_empty),
          int'(q.size() == 0 && !m_busy));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic push_hold(input logic [7:0] b);
    bit acc;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = b;
    do begin
      #2 acc = wr_ready;
      @(negedge clk);
    end while (!acc);
    wr_valid = 1'b0;
  endtask

  task automatic push_force(input logic [7:0] b, output bit rdy);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = b;
    #2 rdy = wr_ready;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (q.size() != 0 || m_busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic pe, input logic ev,
                         input logic sl);
    @(negedge clk);
    char_len = l; par_en = pe; par_even = ev; stop_long = sl;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R10 watchdog expired actual=hung expected=complete");
    finish_run();
  end

  initial begin
    int f0;
    bit r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R1: reset state
    chk(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
    chk(wr_ready == 1'b1, "R1", "reset wr_ready", int'(wr_ready), 1);
    chk(thr_empty == 1'b1, "R1", "reset thr_empty", int'(thr_empty), 1);
    chk(tx_empty == 1'b1, "R1", "reset tx_empty", int'(tx_empty), 1);

    // R2/R7: single-holding mode, 8 bits, no parity, one stop
    f0 = fails;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    push_hold(8'hA5);
    push_hold(8'h66);
    push_force(8'h77, r);
    chk(r == 1'b0, "R7", "ready while holding", int'(r), 0);
    drain();
    chk(fails == f0, "R7", "holding-mode window mismatches", fails - f0, 0);

    // R4: 5-bit, odd parity, 1.5 stop
    f0 = fails;
    set_cfg(2'd0, 1'b1, 1'b0, 1'b1);
    push_hold(8'h1F); push_hold(8'hEA);
    drain();
    chk(fails == f0, "R4", "5-bit long stop window", fails - f0, 0);

    // R3: 7-bit even parity two stop, then 6-bit odd one stop
    f0 = fails;
    set_cfg(2'd2, 1'b1, 1'b1, 1'b1);
    push_hold(8'h5B); drain();
    set_cfg(2'd1, 1'b1, 1'b0, 1'b0);
    push_hold(8'h2C); drain();
    chk(fails == f0, "R3", "parity frames window", fails - f0, 0);

    // R8/R10: queued mode fill and overflow
    f0 = fails;
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0);
    tick_div = 4;
    @(negedge clk) fifo_mode = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 17; i++) push_hold(8'(8'h30 + i * 7));
    #5;
    chk(wr_ready == 1'b0, "R8", "ready when full", int'(wr_ready), 0);
    push_force(8'hEE, r);
    chk(r == 1'b0, "R8", "ready on overflow write", int'(r), 0);
    push_force(8'hDD, r);
    drain();
    chk(fails == f0, "R8", "queued order window", fails - f0, 0);
    chk(fails == f0, "R10", "back-to-back frames window", fails - f0, 0);

    // R5: configuration change in mid-frame
    f0 = fails;
    tick_div = 1;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    push_hold(8'hC3); push_hold(8'h81);
    repeat (40) @(negedge clk);
    char_len = 2'd0; par_en = 1'b1; stop_long = 1'b1;
    drain();
    chk(fails == f0, "R5", "mid-frame config window", fails - f0, 0);

    // R6: break during a frame
    f0 = fails;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    push_hold(8'hFF);
    repeat (20) @(negedge clk);
    brk = 1'b1;
    @(negedge clk); #5;
    chk(txd == 1'b0, "R6", "txd under break", int'(txd), 0);
    repeat (40) @(negedge clk);
    brk = 1'b0;
    drain();
    chk(fails == f0, "R6", "break window", fails - f0, 0);

    // R11: mode change discards waiting bytes
    f0 = fails;
    tick_div = 3;
    @(negedge clk) fifo_mode = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) push_hold(8'(8'h90 + i));
    @(negedge clk) fifo_mode = 1'b0;
    #5;
    chk(wr_ready == 1'b0, "R11", "ready during mode change", int'(wr_ready), 0);
    repeat (2) @(negedge clk); #5;
    chk(thr_empty == 1'b1, "R11", "waiting bytes discarded", int'(thr_empty), 1);
    chk(tx_empty == 1'b0, "R9", "frame still on line", int'(tx_empty), 0);
    drain();
    chk(fails == f0, "R11", "mode change window", fails - f0, 0);

    // R12: sparse baud enables
    f0 = fails;
    tick_div = 5;
    set_cfg(2'd2, 1'b1, 1'b0, 1'b0);
    push_hold(8'h4D); push_hold(8'h12);
    drain();
    chk(fails == f0, "R12", "sparse tick window", fails - f0, 0);

    finish_run();
  end
endmodule